// File: doc/BRIEF.md
# Configuration Stream Decoder with Module Swap and Output Corruption

This block sits on the configuration port of a system with one or more swappable regions. Each region runs one of several candidate modules. Configuration words arrive one per transfer on a valid/ready input. A session opens with a sync word and closes with a desync word. Inside a session, a load header names a target region, a module and a payload length. The block commits the new module selection for that region only if the session closes after exactly that many payload words. It also answers an identification-code query, takes a snapshot of all current selections, and returns that snapshot on a valid/ready readback output.

For the whole of a session, the reconfiguring flag is high. During that time the block replaces every bit that the regions present to the static logic with a fixed alternating pattern. Static logic that acts on those bits during a swap therefore sees obviously wrong data. After a successful commit, a one-cycle swap pulse reports the region and the new module.

Back-pressure works as follows. An input word is taken on a rising edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is low whenever a readback word is waiting. A readback word stays on `rb_data` with `rb_valid` high until a rising edge where `rb_ready` is high.

Top module: `cfg_port_decoder`

## Requirements
- R1: Outside a session, every input word other than the sync word 32'h5A5AC3C3 is ignored. The flag, the selections, the swap pulse and the readback output do not change.
- R2: `reconfiguring` rises in the cycle after the sync word is accepted. It falls in the cycle after the desync word 32'h0D0DF00D is accepted.
- R3: While `reconfiguring` is high, `st_dout` equals the alternating pattern (bit i is 1 exactly when i is odd). Otherwise `st_dout` equals `rr_din`.
- R4: A load header has opcode 8'h01 in bits [31:24], the region in [23:16], the module in [15:8] and the payload word count in [7:0].
- R5: The load commits when desync follows exactly the header's count of payload words. The region's field in `active_sel` (bits [r*MOD_W +: MOD_W]) then takes the new module in the cycle after desync is accepted.
- R6: The previous selection is kept if the payload is shorter or longer than the count, or if the region or module is out of range.
- R7: A commit produces exactly one cycle of `swap_valid` together with the region and module, in the cycle after desync is accepted. There is no pulse otherwise.
- R8: Command opcode 8'h02 inside a session places 32'h0C1B2011 on the readback output.
- R9: Command opcode 8'h03 snapshots all selections. Command opcode 8'h04 returns the last snapshot, zero-extended and laid out like `active_sel`.
- R10: While `rb_valid` is high, `cfg_ready` is low. `rb_data` holds steady until it is taken.
- R11: After reset, all selections are 0, the snapshot is 0, and `reconfiguring`, `swap_valid` and `rb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration word valid |
| cfg_ready | output | 1 | Configuration word accepted when high |
| cfg_data | input | 32 | Configuration word |
| rb_valid | output | 1 | Readback word valid |
| rb_ready | input | 1 | Readback consumer ready |
| rb_data | output | 32 | Readback word |
| reconfiguring | output | 1 | High while a session is open |
| active_sel | output | NUM_REGIONS*MOD_W | Current module per region |
| swap_valid | output | 1 | One-cycle commit pulse |
| swap_region | output | RID_W | Region of the commit |
| swap_module | output | MOD_W | Module of the commit |
| rr_din | input | NUM_REGIONS*OUT_W | Outputs of the regions |
| st_dout | output | NUM_REGIONS*OUT_W | Region outputs as seen by static logic |

## Verification
The bench builds the block with three regions, four modules and 8-bit region outputs. With three regions, a region index of 3 fits the field yet is out of range. With four modules, a module index of 4 is likewise refused. These values make the range checks of R6 reachable by random headers. The three-region snapshot fills six bits, so the per-region packing of R9 is checked across a region that is neither the first nor the last. Random sessions mix exact, short and long payloads with noise before sync.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 8;
  localparam logic [WORD_W-1:0] SYNC_WORD   = 32'h5A5A_C3C3;
  localparam logic [WORD_W-1:0] DESYNC_WORD = 32'h0D0D_F00D;
  localparam logic [WORD_W-1:0] ID_CODE     = 32'h0C1B_2011;
  localparam logic [7:0] OP_LOAD    = 8'h01;
  localparam logic [7:0] OP_IDCODE  = 8'h02;
  localparam logic [7:0] OP_CAPTURE = 8'h03;
  localparam logic [7:0] OP_RDBACK  = 8'h04;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CMD     = 2'd1,
    ST_PAYLOAD = 2'd2
  } pstate_e;
endpackage

// File: rtl/cfgdec_parser.sv
module cfgdec_parser
  import cfgdec_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int NUM_MODULES = 4,
  parameter int RID_W = 1,
  parameter int MOD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_fire,
  input  logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              commit,
  output logic [RID_W-1:0]  commit_region,
  output logic [MOD_W-1:0]  commit_module,
  output logic              capture,
  output logic              push,
  output logic              push_is_id
);
  localparam logic [7:0] NR8 = 8'(NUM_REGIONS);
  localparam logic [7:0] NM8 = 8'(NUM_MODULES);

  pstate_e          state;
  logic [LEN_W:0]   cnt;
  logic [LEN_W-1:0] hdr_len;
  logic [RID_W-1:0] hdr_reg;
  logic [MOD_W-1:0] hdr_mod;
  logic             hdr_bad;

  logic [7:0] f_op, f_reg, f_mod;
  logic       is_sync, is_desync, in_cmd;

  assign f_op      = word[31:24];
  assign f_reg     = word[23:16];
  assign f_mod     = word[15:8];
  assign is_sync   = (word == SYNC_WORD);
  assign is_desync = (word == DESYNC_WORD);
  assign in_cmd    = word_fire && (state == ST_CMD) && !is_desync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      hdr_len <= '0;
      hdr_reg <= '0;
      hdr_mod <= '0;
      hdr_bad <= 1'b0;
    end else if (word_fire) begin
      case (state)
        ST_IDLE: if (is_sync) state <= ST_CMD;
        ST_CMD: begin
          if (is_desync) begin
            state <= ST_IDLE;
          end else if (f_op == OP_LOAD) begin
            state   <= ST_PAYLOAD;
            cnt     <= '0;
            hdr_len <= word[LEN_W-1:0];
            hdr_reg <= f_reg[RID_W-1:0];
            hdr_mod <= f_mod[MOD_W-1:0];
            hdr_bad <= (f_reg >= NR8) || (f_mod >= NM8);
          end
        end
        ST_PAYLOAD: begin
          if (is_desync) state <= ST_IDLE;
          else if (cnt != '1) cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign commit        = word_fire && (state == ST_PAYLOAD) && is_desync &&
                         (cnt == {1'b0, hdr_len}) && !hdr_bad;
  assign commit_region = hdr_reg;
  assign commit_module = hdr_mod;
  assign capture       = in_cmd && (f_op == OP_CAPTURE);
  assign push_is_id    = (f_op == OP_IDCODE);
  assign push          = in_cmd && ((f_op == OP_IDCODE) || (f_op == OP_RDBACK));
endmodule

// File: rtl/cfgdec_selbank.sv
module cfgdec_selbank #(
  parameter int NUM_REGIONS = 2,
  parameter int RID_W = 1,
  parameter int MOD_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [RID_W-1:0]             commit_region,
  input  logic [MOD_W-1:0]             commit_module,
  input  logic                         capture,
  output logic [NUM_REGIONS*MOD_W-1:0] sel_flat,
  output logic [NUM_REGIONS*MOD_W-1:0] snap_flat,
  output logic                         swap_valid,
  output logic [RID_W-1:0]             swap_region,
  output logic [MOD_W-1:0]             swap_module
);
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    logic [MOD_W-1:0] sel_q;
    always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= '0;
      else if (commit && (commit_region == RID_W'(r))) sel_q <= commit_module;
    end
    assign sel_flat[r*MOD_W +: MOD_W] = sel_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_flat   <= '0;
      swap_valid  <= 1'b0;
      swap_region <= '0;
      swap_module <= '0;
    end else begin
      if (capture) snap_flat <= sel_flat;
      swap_valid <= commit;
      if (commit) begin
        swap_region <= commit_region;
        swap_module <= commit_module;
      end
    end
  end
endmodule

// File: rtl/cfgdec_rbslot.sv
module cfgdec_rbslot #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  output logic             slot_free,
  output logic             rb_valid,
  input  logic             rb_ready,
  output logic [WIDTH-1:0] rb_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_valid <= 1'b0;
      rb_data  <= '0;
    end else if (push) begin
      rb_valid <= 1'b1;
      rb_data  <= push_data;
    end else if (rb_ready) begin
      rb_valid <= 1'b0;
    end
  end
  assign slot_free = !rb_valid;
endmodule

// File: rtl/cfgdec_isolate.sv
module cfgdec_isolate #(
  parameter int WIDTH = 16
) (
  input  logic             corrupt,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign dout[i] = corrupt ? 1'((i % 2) == 1) : din[i];
  end
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfgdec_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int NUM_MODULES = 4,
  parameter int OUT_W = 16,
  localparam int RID_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int MOD_W = (NUM_MODULES > 1) ? $clog2(NUM_MODULES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_valid,
  output logic                         cfg_ready,
  input  logic [WORD_W-1:0]            cfg_data,
  output logic                         rb_valid,
  input  logic                         rb_ready,
  output logic [WORD_W-1:0]            rb_data,
  output logic                         reconfiguring,
  output logic [NUM_REGIONS*MOD_W-1:0] active_sel,
  output logic                         swap_valid,
  output logic [RID_W-1:0]             swap_region,
  output logic [MOD_W-1:0]             swap_module,
  input  logic [NUM_REGIONS*OUT_W-1:0] rr_din,
  output logic [NUM_REGIONS*OUT_W-1:0] st_dout
);
  logic                         word_fire, commit, capture, push, push_is_id;
  logic [RID_W-1:0]             commit_region;
  logic [MOD_W-1:0]             commit_module;
  logic [NUM_REGIONS*MOD_W-1:0] snap_flat;
  logic [WORD_W-1:0]            push_data;
  logic                         slot_free;

  assign cfg_ready = slot_free;
  assign word_fire = cfg_valid && cfg_ready;
  assign push_data = push_is_id ? ID_CODE : WORD_W'(snap_flat);

  cfgdec_parser #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_MODULES(NUM_MODULES),
    .RID_W(RID_W), .MOD_W(MOD_W)
  ) u_parser (
    .clk(clk), .rst_n(rst_n), .word_fire(word_fire), .word(cfg_data),
    .busy(reconfiguring), .commit(commit), .commit_region(commit_region),
    .commit_module(commit_module), .capture(capture), .push(push),
    .push_is_id(push_is_id)
  );

  cfgdec_selbank #(
    .NUM_REGIONS(NUM_REGIONS), .RID_W(RID_W), .MOD_W(MOD_W)
  ) u_selbank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_region(commit_region),
    .commit_module(commit_module), .capture(capture), .sel_flat(active_sel),
    .snap_flat(snap_flat), .swap_valid(swap_valid), .swap_region(swap_region),
    .swap_module(swap_module)
  );

  cfgdec_rbslot #(.WIDTH(WORD_W)) u_rbslot (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .slot_free(slot_free), .rb_valid(rb_valid), .rb_ready(rb_ready),
    .rb_data(rb_data)
  );

  cfgdec_isolate #(.WIDTH(NUM_REGIONS*OUT_W)) u_isolate (
    .corrupt(reconfiguring), .din(rr_din), .dout(st_dout)
  );
endmodule

// File: rtl/cfgdec_chk.sv
module cfgdec_chk
  import cfgdec_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int OUT_W = 16,
  parameter int RID_W = 1,
  parameter int MOD_W = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_valid,
  input logic                         cfg_ready,
  input logic [WORD_W-1:0]            cfg_data,
  input logic                         rb_valid,
  input logic                         rb_ready,
  input logic [WORD_W-1:0]            rb_data,
  input logic                         reconfiguring,
  input logic [NUM_REGIONS*MOD_W-1:0] active_sel,
  input logic                         swap_valid,
  input logic [RID_W-1:0]             swap_region,
  input logic [MOD_W-1:0]             swap_module,
  input logic [NUM_REGIONS*OUT_W-1:0] rr_din,
  input logic [NUM_REGIONS*OUT_W-1:0] st_dout
);
  localparam logic [NUM_REGIONS*OUT_W-1:0] PAT = {(NUM_REGIONS*OUT_W){2'b10}} >> 0;

  // R2
  sync_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reconfiguring) |-> $past(cfg_valid && cfg_ready && cfg_data == SYNC_WORD));

  // R2
  desync_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reconfiguring) |-> $past(cfg_valid && cfg_ready && cfg_data == DESYNC_WORD));

  // R3
  corrupt_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reconfiguring |-> (st_dout == PAT));

  // R3
  pass_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reconfiguring |-> (st_dout == rr_din));

  // R6
  sel_only_on_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_sel) |-> swap_valid);

  // R7
  swap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_valid |=> !swap_valid);

  // R7
  swap_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_valid |-> (!reconfiguring && $past(reconfiguring) &&
                    32'(swap_region) < NUM_REGIONS &&
                    active_sel[swap_region*MOD_W +: MOD_W] == swap_module));

  // R10
  hold_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> !cfg_ready);

  // R10
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_ready) |=> (rb_valid && $stable(rb_data)));
endmodule

bind cfg_port_decoder cfgdec_chk #(
  .NUM_REGIONS(NUM_REGIONS), .OUT_W(OUT_W), .RID_W(RID_W), .MOD_W(MOD_W)
) u_chk (.*);

// File: tb/tb_cfg_port_decoder.sv
module tb_cfg_port_decoder;
  timeunit 1ns; timeprecision 1ps;
  import cfgdec_pkg::*;

  localparam int NR = 3, NM = 4, OW = 8, MW = 2, RW = 2;
  localparam logic [NR*OW-1:0] PAT = {(NR*OW/2){2'b10}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 1'b0, rb_ready = 1'b1;
  logic [31:0] cfg_data = '0;
  logic cfg_ready, rb_valid, reconfiguring, swap_valid;
  logic [31:0] rb_data;
  logic [NR*MW-1:0] active_sel;
  logic [RW-1:0] swap_region;
  logic [MW-1:0] swap_module;
  logic [NR*OW-1:0] rr_din = '0, st_dout;

  int n_cmp = 0, n_bad = 0;
  logic [MW-1:0] exp_sel [NR];
  logic [NR*MW-1:0] exp_snap;

  always #2 clk = ~clk;

  cfg_port_decoder #(.NUM_REGIONS(NR), .NUM_MODULES(NM), .OUT_W(OW)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NR*MW-1:0] pack_sel();
    logic [NR*MW-1:0] v = '0;
    for (int r = 0; r < NR; r++) v[r*MW +: MW] = exp_sel[r];
    return v;
  endfunction

  function automatic logic [31:0] noise();
    logic [31:0] w = $urandom;
    if (w == SYNC_WORD || w == DESYNC_WORD) w = w ^ 32'h1;
    return w;
  endfunction

  function automatic logic [31:0] load_hdr(input int r, input int m, input int n);
    return {OP_LOAD, 8'(r), 8'(m), 8'(n)};
  endfunction

  // returns at the falling edge after the accepting rising edge
  task automatic send(input logic [31:0] w);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_data  = w;
    while (!cfg_ready) @(negedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic load_session(input int r, input int m, input int n, input int plen,
                              input int pre);
    logic ok;
    for (int i = 0; i < pre; i++) send(noise());
    rr_din = NR*OW'($urandom);
    send(SYNC_WORD);
    chk("R2 flag after sync", 32'(reconfiguring), 32'd1);
    chk("R3 corrupt pattern", 32'(st_dout), 32'(PAT));
    send(load_hdr(r, m, n));
    for (int i = 0; i < plen; i++) send(noise());
    send(DESYNC_WORD);
    ok = (r < NR) && (m < NM) && (plen == n);
    chk("R7 swap pulse", 32'(swap_valid), 32'(ok));
    if (ok) begin
      chk("R7 swap region", 32'(swap_region), 32'(r));
      chk("R7 swap module", 32'(swap_module), 32'(m));
      exp_sel[r] = MW'(m);
    end
    chk("R2 flag after desync", 32'(reconfiguring), 32'd0);
    chk("R3 passthrough", 32'(st_dout), 32'(rr_din));
    chk(ok ? "R5 commit" : "R6 keep old", 32'(active_sel), 32'(pack_sel()));
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int r = 0; r < NR; r++) exp_sel[r] = '0;
    exp_snap = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 flag", 32'(reconfiguring), 32'd0);
    chk("R11 sel", 32'(active_sel), 32'd0);
    chk("R11 rb_valid", 32'(rb_valid), 32'd0);
    chk("R11 swap", 32'(swap_valid), 32'd0);
    chk("R10 ready idle", 32'(cfg_ready), 32'd1);

    // R1 words before sync are ignored
    rr_din = 24'h123456;
    send(load_hdr(0, 2, 0));
    send({OP_IDCODE, 24'h0});
    send(DESYNC_WORD);
    chk("R1 flag", 32'(reconfiguring), 32'd0);
    chk("R1 swap", 32'(swap_valid), 32'd0);
    chk("R1 rb_valid", 32'(rb_valid), 32'd0);
    chk("R1 sel", 32'(active_sel), 32'd0);
    chk("R3 idle passthrough", 32'(st_dout), 32'(rr_din));

    // R4 R5 zero-length load, last region
    load_session(2, 3, 0, 0, 0);
    // R6 truncated payload
    load_session(1, 2, 3, 1, 0);
    // R6 overlong payload
    load_session(1, 2, 1, 2, 0);
    // R6 module out of range
    load_session(0, 4, 0, 0, 0);
    // R6 region out of range
    load_session(3, 1, 0, 0, 0);
    // R5 region 1 exact
    load_session(1, 1, 2, 2, 1);

    // R8 identification code
    send(SYNC_WORD);
    send({OP_IDCODE, 24'h0});
    chk("R8 rb_valid", 32'(rb_valid), 32'd1);
    chk("R8 idcode", rb_data, 32'h0C1B2011);
    chk("R10 ready held", 32'(cfg_ready), 32'd0);

    // R9 capture then readback
    send({OP_CAPTURE, 24'h0});
    exp_snap = pack_sel();
    send({OP_RDBACK, 24'h0});
    chk("R9 snapshot", rb_data, 32'(exp_snap));
    send(DESYNC_WORD);
    load_session(0, 3, 1, 1, 0);
    send(SYNC_WORD);
    send({OP_RDBACK, 24'h0});
    chk("R9 snapshot kept", rb_data, 32'(exp_snap));
    send(DESYNC_WORD);

    // R10 back-pressure on readback
    rb_ready = 1'b0;
    send(SYNC_WORD);
    send({OP_IDCODE, 24'h0});
    repeat (3) @(negedge clk);
    chk("R10 rb_valid held", 32'(rb_valid), 32'd1);
    chk("R10 data held", rb_data, 32'h0C1B2011);
    chk("R10 input stalled", 32'(cfg_ready), 32'd0);
    rb_ready = 1'b1;
    @(negedge clk);
    chk("R10 taken", 32'(rb_valid), 32'd0);
    send(DESYNC_WORD);

    // random sessions
    for (int k = 0; k < 60; k++) begin
      int r = $urandom % 4;
      int m = $urandom % 5;
      int n = $urandom % 6;
      int mode = $urandom % 4;
      int plen = (mode == 2) ? ((n > 0) ? n - 1 : n + 1) : ((mode == 3) ? n + 1 : n);
      load_session(r, m, n, plen, $urandom % 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule